// File: doc/BRIEF.md
# Interrupt priority mask filter

This block sits between an interrupt prioritiser and the core's exception entry logic. Each cycle it receives the highest requested interrupt level (0 means no request) and the 3-bit priority mask held in the status register. It decides whether the request may be taken. When it can, it issues a single-cycle take strobe together with the accepted level.

Levels 1 to 6 are level-sensitive and pass only when they are strictly above the mask, so the mask is inclusive. Level 7 cannot be masked, even by a mask of 7, and it is edge-sensitive. A move of the requested level from below 7 up to 7 latches a pending non-maskable request. Holding the request at 7 adds nothing more. A pending level-7 request wins over any lower level and is cleared in the cycle it is taken. Because take strobes are never back to back, a held maskable request is taken again every second cycle until the core raises the mask.

Top module: `irq_mask_filter`

## Requirements
- R1: While reset is asserted and after its release with no request, take_o is 0 and take_lvl_o is 0.
- R2: A request at level 1 to 6 that is strictly greater than the mask value (unsigned, 0 to 7) sampled at a clock edge raises take_o in the following cycle, with take_lvl_o equal to that level. A request at or below the mask is not taken.
- R3: A requested level of 0 never raises take_o.
- R4: A rise of the requested level from below 7 to 7 is taken for every mask value, 7 included, with take_lvl_o equal to 7.
- R5: Holding the requested level at 7 produces no further take. A new take at level 7 needs the level to drop below 7 and rise to 7 again.
- R6: A level-7 rise that cannot be taken at once stays pending. It is taken at the next opportunity, ahead of any lower level requested at that time, and the pending state is cleared when it is taken.
- R7: take_o is never high in two consecutive cycles. A maskable request that stays valid is taken again two cycles after its previous take.
- R8: take_lvl_o changes only in the cycle a take is issued, and it keeps the accepted level otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_lvl_i | input | 3 | Highest requested interrupt level from the prioritiser, 0 = none |
| mask_i | input | 3 | Interrupt priority mask from the status register |
| take_o | output | 1 | One-cycle strobe: the interrupt is taken |
| take_lvl_o | output | 3 | Level of the most recently taken interrupt |

## Verification
On every cycle the assertions check four things. A strobe is always followed by a quiet cycle. A maskable take always had its level above the mask on the cycle before. Every level-7 take comes from a detected rise or a pending rise. A pending rise with the strobe idle is always served at once. Only the bench scenarios can show the rest. The full sweep of mask against level shows that the inclusive comparison is exact. Holding a request at 7 shows that no second take follows. A level-7 rise that collides with a strobe shows that it is pended and then served ahead of a lower request.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int unsigned LVL_W = 3;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] req_lvl_i,
  input  logic             taken_i,
  output logic             edge_o,
  output logic             pend_o
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

  logic is_top, was_top_q, pend_q;

  assign is_top = (req_lvl_i == TOP);
  assign edge_o = is_top & ~was_top_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      was_top_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      was_top_q <= is_top;
      pend_q    <= (pend_q | edge_o) & ~taken_i;
    end
  end

  // R5: a held top level never yields a fresh edge
  a_r5_no_edge_when_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_top |=> (is_top -> !edge_o));
endmodule

// File: rtl/irq_lvl_gate.sv
module irq_lvl_gate #(
  parameter int unsigned LVL_W = 3
) (
  input  logic [LVL_W-1:0] req_lvl_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             nmi_edge_i,
  input  logic             nmi_pend_i,
  output logic             cand_vld_o,
  output logic [LVL_W-1:0] cand_lvl_o
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

  logic maskable_ok;

  // inclusive mask; top level handled only through the edge path
  assign maskable_ok = (req_lvl_i != '0) && (req_lvl_i != TOP) && (req_lvl_i > mask_i);

  always_comb begin
    if (nmi_edge_i || nmi_pend_i) begin
      cand_vld_o = 1'b1;
      cand_lvl_o = TOP;
    end else if (maskable_ok) begin
      cand_vld_o = 1'b1;
      cand_lvl_o = req_lvl_i;
    end else begin
      cand_vld_o = 1'b0;
      cand_lvl_o = '0;
    end
  end
endmodule

// File: rtl/irq_take_reg.sv
module irq_take_reg #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cand_vld_i,
  input  logic [LVL_W-1:0] cand_lvl_i,
  output logic             issue_o,
  output logic             take_o,
  output logic [LVL_W-1:0] take_lvl_o
);
  logic             take_q;
  logic [LVL_W-1:0] lvl_q;

  // one idle cycle after every strobe
  assign issue_o    = cand_vld_i & ~take_q;
  assign take_o     = take_q;
  assign take_lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      lvl_q  <= '0;
    end else begin
      take_q <= issue_o;
      if (issue_o) lvl_q <= cand_lvl_i;
    end
  end

  a_r7_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
  a_r8_lvl_stable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> $stable(take_lvl_o));
  a_r3_lvl_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (take_lvl_o != '0));
endmodule

// File: rtl/irq_mask_filter.sv
module irq_mask_filter
  import irq_mask_pkg::*;
#(
  parameter int unsigned W = LVL_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_lvl_i,
  input  logic [W-1:0] mask_i,
  output logic         take_o,
  output logic [W-1:0] take_lvl_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         nmi_edge, nmi_pend, nmi_taken;
  logic         cand_vld, issue;
  logic [W-1:0] cand_lvl;

  assign nmi_taken = issue & (cand_lvl == TOP);

  irq_nmi_edge #(.LVL_W(W)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_lvl_i (req_lvl_i),
    .taken_i   (nmi_taken),
    .edge_o    (nmi_edge),
    .pend_o    (nmi_pend)
  );

  irq_lvl_gate #(.LVL_W(W)) u_gate (
    .req_lvl_i  (req_lvl_i),
    .mask_i     (mask_i),
    .nmi_edge_i (nmi_edge),
    .nmi_pend_i (nmi_pend),
    .cand_vld_o (cand_vld),
    .cand_lvl_o (cand_lvl)
  );

  irq_take_reg #(.LVL_W(W)) u_take (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cand_vld_i (cand_vld),
    .cand_lvl_i (cand_lvl),
    .issue_o    (issue),
    .take_o     (take_o),
    .take_lvl_o (take_lvl_o)
  );

  a_r2_above_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && cand_lvl != TOP) |=> (take_o && $past(req_lvl_i) > $past(mask_i)));
  a_r4_top_from_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue && cand_lvl == TOP |-> (nmi_edge || nmi_pend));
  a_r6_pend_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend && !take_o) |=> (take_o && take_lvl_o == TOP));
endmodule

// File: tb/sim_irq_mask_filter.sv
module sim_irq_mask_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0;
  logic [2:0] msk = '0;
  logic       take;
  logic [2:0] lvl;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_mask_filter u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_lvl_i(req), .mask_i(msk),
    .take_o(take), .take_lvl_o(lvl)
  );

  task automatic chk(input string r, input logic et, input logic [2:0] el);
    checks++;
    if (take !== et || (et && lvl !== el)) begin
      fails++;
      $display("FAIL %s: take=%0b lvl=%0d expected take=%0b lvl=%0d", r, take, lvl, et, el);
    end
  endtask

  // drive at negedge, sample just after the next rising edge
  task automatic step(input logic [2:0] r, input logic [2:0] m);
    @(negedge clk);
    req = r;
    msk = m;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    chk("R1", 1'b0, 3'd0);
    if (lvl !== 3'd0) begin
      fails++;
      $display("FAIL R1: lvl=%0d expected 0", lvl);
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(3'd0, 3'd0);
    chk("R1", 1'b0, 3'd0);

    for (int m = 0; m < 8; m++) begin
      for (int r = 0; r < 8; r++) begin
        logic exp;
        exp = (r == 7) || (r != 0 && r > m);
        step(3'd0, 3'(m));
        step(3'd0, 3'(m));
        step(3'(r), 3'(m));
        chk(r == 7 ? "R4" : (r == 0 ? "R3" : "R2"), exp, 3'(r));
        step(3'(r), 3'(m));
        chk(r == 7 ? "R5" : "R7", 1'b0, 3'd0);
        step(3'(r), 3'(m));
        chk(r == 7 ? "R5" : "R7", (r != 7) && exp, 3'(r));
      end
    end

    // R5: long hold at 7, then drop and rise again
    step(3'd0, 3'd7);
    step(3'd7, 3'd7);
    chk("R5", 1'b1, 3'd7);
    for (int i = 0; i < 5; i++) begin
      step(3'd7, 3'd7);
      chk("R5", 1'b0, 3'd0);
    end
    step(3'd6, 3'd7);
    chk("R5", 1'b0, 3'd0);
    step(3'd7, 3'd7);
    chk("R5", 1'b1, 3'd7);

    // R6: rise during a strobe is pended, then wins over a lower level
    step(3'd0, 3'd0);
    step(3'd0, 3'd0);
    step(3'd3, 3'd0);
    chk("R6", 1'b1, 3'd3);
    step(3'd7, 3'd0);
    chk("R6", 1'b0, 3'd0);
    step(3'd5, 3'd0);
    chk("R6", 1'b1, 3'd7);
    step(3'd5, 3'd0);
    chk("R6", 1'b0, 3'd0);
    step(3'd5, 3'd0);
    chk("R6", 1'b1, 3'd5);

    // R8: level holds through idle cycles
    step(3'd0, 3'd0);
    step(3'd0, 3'd0);
    checks++;
    if (lvl !== 3'd5) begin
      fails++;
      $display("FAIL R8: lvl=%0d expected 5", lvl);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule